// File: doc/BRIEF.md
# Addend-Tuned Precision Time Clock

This block keeps a 64-bit precision system time for a network controller. A 32-bit rate accumulator adds a programmable addend on every reference clock. Each carry out of its top bit advances the system time by one tick, where one tick stands for 32 ns. Software converts a tick count to nanoseconds by shifting it left by five. Frequency is trimmed by rewriting the addend a few parts per billion above or below its nominal value.

Software reaches the block through a simple 32-bit register port. Through it, software can:
- load and read the time as a pair of words;
- arm a 64-bit target time;
- read two snapshot register pairs, each frozen by a rising edge on its own external event input;
- acknowledge events in a write-one-to-clear event register, whose unmasked bits drive an interrupt line.

A control bit holds the time-keeping logic in reset for as long as it stays set.

Top module: `tstamp_clock`

## Requirements
- R1: After `rst_n` is released, reads return these values: control (word 0) = 0, event (word 1) = 0, addend (word 2) = 0xA0000000, target and snapshot words = 0. `irq` is 0.
- R2: Each clock cycle, the accumulator adds the addend. A carry out of bit 31 adds one to system time. When the accumulator starts from 0, k cycles later the time equals floor(k * addend / 2^32).
- R3: A read of time-low (word 3) copies the current high word into a shadow. Reads of time-high (word 4) return that shadow until the next time-low read.
- R4: A write to time-low only stages the value. A write to time-high loads the time as {written high, staged low} in one step.
- R5: A write to target-high (word 6) loads the target as {written high, staged target-low (word 5)} and arms the compare. While armed, time >= target sets event bit 1 once and disarms.
- R6: A rising edge on `ext_evt[i]` passes a two-flop synchroniser. It then copies the time into snapshot pair i (words 7/8 for channel 0, words 9/10 for channel 1, low then high) and sets event bit 2+i. A level held high has no further effect.
- R7: A new edge while a snapshot flag is still set overwrites that snapshot.
- R8: Writing word 1 clears each event bit written as one. Bits written as zero are unchanged.
- R9: Event bit 4 has no source in this block and always reads 0. Control bits 4:0 read back as written.
- R10: `irq` is the OR over bits 1 to 4 of (event bit AND control bit at the same position).
- R11: While control bit 0 is one, these are held at zero: accumulator, time, event bits and snapshots. Loads of the time are ignored. Addend, target and control are kept.
- R12: The addend register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ext_evt | input | 2 | External snapshot event inputs |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the register port carries at most one access per cycle. They also assume that the time only jumps when a high word is loaded. The ones on the event register assume that a clear does not race a new set of the same bit.

The stimulus keeps to one access per clock. It freezes time with a zero addend wherever a snapshot or compare value must be exact. It waits enough cycles after each external edge for the synchroniser before reading.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned SNAP_CH = 2;
  localparam int unsigned ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVT    = 4'd1;
  localparam logic [ADDR_W-1:0] A_ADDEND = 4'd2;
  localparam logic [ADDR_W-1:0] A_TLO    = 4'd3;
  localparam logic [ADDR_W-1:0] A_THI    = 4'd4;
  localparam logic [ADDR_W-1:0] A_GLO    = 4'd5;
  localparam logic [ADDR_W-1:0] A_GHI    = 4'd6;
  localparam int unsigned       SNAP_BASE = 7;

  localparam int unsigned B_SRST  = 0;
  localparam int unsigned B_TGT   = 1;
  localparam int unsigned B_SNAP0 = 2;
  localparam int unsigned B_PPS   = 4;
  localparam int unsigned CTRL_W  = B_PPS + 1;

  localparam logic [DW-1:0] ADDEND_RST = 32'hA000_0000;
endpackage

// File: rtl/tstamp_rate_acc.sv
module tstamp_rate_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [ACC_W-1:0] addend,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, addend};
    acc_d   = soft_rst ? '0 : sum[ACC_W-1:0];
    carry_o = !soft_rst && sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // without a carry, a nonzero addend makes the accumulator grow
  assert_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && addend != '0 && !carry_o) |=> (acc_q > $past(acc_q)))
    else $error("accumulator did not grow");
endmodule

// File: rtl/tstamp_time_base.sv
module tstamp_time_base #(
  parameter int unsigned HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            rd_lo,
  input  logic [HW-1:0]   wdata,
  output logic [2*HW-1:0] time_o,
  output logic [HW-1:0]   shadow_o
);
  localparam int unsigned TW = 2 * HW;

  logic [TW-1:0] time_q, time_d;
  logic [HW-1:0] stage_q, shadow_q;
  logic          time_en;

  always_comb begin
    time_en = soft_rst || wr_hi || tick;
    if (soft_rst)   time_d = '0;
    else if (wr_hi) time_d = {wdata, stage_q};
    else            time_d = time_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (time_en) time_q   <= time_d;
      if (wr_lo)   stage_q  <= wdata;
      if (rd_lo)   shadow_q <= time_q[TW-1:HW];
    end
  end

  assign time_o   = time_q;
  assign shadow_o = shadow_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !wr_hi) |=> (time_q == $past(time_q) || time_q == $past(time_q) + TW'(1)))
    else $error("time moved by more than one tick");

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (time_q == '0))
    else $error("time not held in soft reset");
endmodule

// File: rtl/tstamp_target_cmp.sv
module tstamp_target_cmp #(
  parameter int unsigned HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  input  logic [2*HW-1:0] time_i,
  output logic [2*HW-1:0] tgt_o,
  output logic            hit_o
);
  localparam int unsigned TW = 2 * HW;

  logic [TW-1:0] tgt_q;
  logic [HW-1:0] stage_q;
  logic          armed_q, armed_d;

  always_comb begin
    hit_o = armed_q && !soft_rst && (time_i >= tgt_q);
    if (wr_hi)      armed_d = 1'b1;
    else if (hit_o) armed_d = 1'b0;
    else            armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      stage_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_lo) stage_q <= wdata;
      if (wr_hi) tgt_q   <= {wdata, stage_q};
      armed_q <= armed_d;
    end
  end

  assign tgt_o = tgt_q;

  assert_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !wr_hi) |=> !hit_o)
    else $error("target hit repeated without rearm");
endmodule

// File: rtl/tstamp_snap_chan.sv
module tstamp_snap_chan #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          evt_in,
  input  logic [TW-1:0] time_i,
  output logic [TW-1:0] snap_o,
  output logic          hit_o
);
  logic          s1_q, s2_q, s3_q;
  logic [TW-1:0] snap_q;
  logic          snap_en;

  always_comb begin
    hit_o   = s2_q && !s3_q && !soft_rst;
    snap_en = hit_o || soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      s1_q <= evt_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (snap_en) snap_q <= soft_rst ? '0 : time_i;
    end
  end

  assign snap_o = snap_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_o && !soft_rst) |=> $stable(snap_q))
    else $error("snapshot changed without an edge");
endmodule

// File: rtl/tstamp_clock.sv
module tstamp_clock
  import tstamp_pkg::*;
#(
  parameter int unsigned ACC_W = DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [SNAP_CH-1:0] ext_evt,
  output logic               irq
);
  localparam int unsigned TW = 2 * DW;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [ACC_W-1:0]   addend_q;
  logic [B_PPS:B_TGT] evt_q, evt_d, evt_set, evt_clr;
  logic [DW-1:0]      rdata_q, rdata_d;
  logic               soft_rst, tick, tgt_hit, rd;
  logic               wr_ctrl, wr_evt, wr_add, wr_tlo, wr_thi, wr_glo, wr_ghi, rd_tlo;
  logic [TW-1:0]      time_w, tgt_w;
  logic [DW-1:0]      shadow_w;
  logic [TW-1:0]      snap_w [SNAP_CH];
  logic [SNAP_CH-1:0] snap_hit;

  always_comb begin
    rd      = bus_sel && !bus_wr;
    wr_ctrl = bus_sel && bus_wr && bus_addr == A_CTRL;
    wr_evt  = bus_sel && bus_wr && bus_addr == A_EVT;
    wr_add  = bus_sel && bus_wr && bus_addr == A_ADDEND;
    wr_tlo  = bus_sel && bus_wr && bus_addr == A_TLO;
    wr_thi  = bus_sel && bus_wr && bus_addr == A_THI;
    wr_glo  = bus_sel && bus_wr && bus_addr == A_GLO;
    wr_ghi  = bus_sel && bus_wr && bus_addr == A_GHI;
    rd_tlo  = rd && bus_addr == A_TLO;
    soft_rst = ctrl_q[B_SRST];
  end

  tstamp_rate_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .addend(addend_q), .carry_o(tick)
  );

  tstamp_time_base #(.HW(DW)) u_time (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick),
    .wr_lo(wr_tlo), .wr_hi(wr_thi), .rd_lo(rd_tlo), .wdata(bus_wdata),
    .time_o(time_w), .shadow_o(shadow_w)
  );

  tstamp_target_cmp #(.HW(DW)) u_tgt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_lo(wr_glo), .wr_hi(wr_ghi), .wdata(bus_wdata),
    .time_i(time_w), .tgt_o(tgt_w), .hit_o(tgt_hit)
  );

  for (genvar g = 0; g < SNAP_CH; g++) begin : g_snap
    tstamp_snap_chan #(.TW(TW)) u_snap (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .evt_in(ext_evt[g]), .time_i(time_w),
      .snap_o(snap_w[g]), .hit_o(snap_hit[g])
    );
  end

  // event register: set sources win over a clear in the same cycle
  always_comb begin
    evt_set = '0;
    evt_set[B_TGT] = tgt_hit;
    for (int i = 0; i < SNAP_CH; i++) evt_set[B_SNAP0 + i] = snap_hit[i];
    evt_clr = wr_evt ? bus_wdata[B_PPS:B_TGT] : '0;
    evt_d   = soft_rst ? '0 : ((evt_q & ~evt_clr) | evt_set);
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      A_CTRL:   rdata_d = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      A_EVT:    rdata_d = {{(DW-B_PPS-1){1'b0}}, evt_q, 1'b0};
      A_ADDEND: rdata_d = addend_q;
      A_TLO:    rdata_d = time_w[DW-1:0];
      A_THI:    rdata_d = shadow_w;
      A_GLO:    rdata_d = tgt_w[DW-1:0];
      A_GHI:    rdata_d = tgt_w[TW-1:DW];
      default:  rdata_d = '0;
    endcase
    for (int i = 0; i < SNAP_CH; i++) begin
      if (bus_addr == ADDR_W'(SNAP_BASE + 2*i))     rdata_d = snap_w[i][DW-1:0];
      if (bus_addr == ADDR_W'(SNAP_BASE + 2*i + 1)) rdata_d = snap_w[i][TW-1:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      addend_q <= ADDEND_RST;
      evt_q    <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= bus_wdata[CTRL_W-1:0];
      if (wr_add)  addend_q <= bus_wdata;
      evt_q <= evt_d;
      if (rd)      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(evt_q & ctrl_q[B_PPS:B_TGT]);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[B_TGT] && !tgt_hit) |=> !evt_q[B_TGT])
    else $error("target flag not cleared");

  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[B_SNAP0]) |-> $past(snap_hit[0]))
    else $error("snapshot flag rose without an edge");

  assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_PPS:B_TGT] == '0) |-> !irq)
    else $error("irq with all masks off");

  assert_srst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (evt_q == '0))
    else $error("events not held in soft reset");
endmodule

// File: tb/tstamp_clock_tb_top.sv
`timescale 1ns/1ps
module tstamp_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  ext_evt;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        rd_evt;

  always #2.5 clk = ~clk;

  tstamp_clock dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_evt(ext_evt), .irq(irq)
  );

  function automatic logic [31:0] ticks(input int k, input logic [31:0] add);
    logic [63:0] p;
    p = 64'(k) * 64'(add);
    return p[63:32];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 0;
    #1 -> rd_evt;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", t, got, e);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [31:0] e;
      string t;
      @(rd_evt);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s got=%h exp=%h", t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ext_evt = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk(irq, 1'b0, "R1 irq");
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 event");
    rd(4'd2, 32'hA000_0000, "R1 addend");
    rd(4'd6, 32'h0, "R1 target hi");
    rd(4'd7, 32'h0, "R1 snap0 lo");
    // R11 hold in soft reset, R2 rate
    wr(4'd0, 32'h1);
    idle(5);
    rd(4'd3, 32'h0, "R11 time lo held");
    wr(4'd0, 32'h0);
    idle(100);
    rd(4'd3, ticks(100, 32'hA000_0000), "R2 nominal rate");
    rd(4'd4, 32'h0, "R2 hi");
    wr(4'd2, 32'h4000_0000);
    rd(4'd2, 32'h4000_0000, "R12 addend readback");
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h0);
    idle(40);
    rd(4'd3, ticks(40, 32'h4000_0000), "R2 trimmed rate");
    // R4 staged load, frozen time
    wr(4'd2, 32'h0);
    wr(4'd3, 32'hAAAA_0000);
    wr(4'd4, 32'h7);
    wr(4'd3, 32'h1111_2222);
    rd(4'd3, 32'hAAAA_0000, "R4 low write staged");
    rd(4'd4, 32'h7, "R4 hi");
    wr(4'd4, 32'h9);
    rd(4'd3, 32'h1111_2222, "R4 loaded lo");
    rd(4'd4, 32'h9, "R4 loaded hi");
    // R3 coherent read across rollover
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd4, 32'h5);
    rd(4'd3, 32'hFFFF_FFFF, "R3 lo");
    wr(4'd2, 32'hFFFF_FFFF);
    idle(3);
    rd(4'd4, 32'h5, "R3 shadow hi");
    rd(4'd4, 32'h5, "R3 shadow kept");
    rd(4'd3, 32'h3, "R3 lo after roll");
    rd(4'd4, 32'h6, "R3 new hi");
    wr(4'd2, 32'h0);
    // R5 target compare
    wr(4'd3, 32'd100);
    wr(4'd4, 32'h0);
    wr(4'd5, 32'd105);
    wr(4'd6, 32'h0);
    idle(2);
    rd(4'd1, 32'h0, "R5 not reached");
    rd(4'd5, 32'd105, "R5 target lo");
    wr(4'd3, 32'd105);
    wr(4'd4, 32'h0);
    idle(2);
    rd(4'd1, 32'h2, "R5 reached");
    chk(irq, 1'b0, "R10 masked");
    wr(4'd0, 32'h2);
    chk(irq, 1'b1, "R10 unmasked");
    wr(4'd1, 32'h2);
    idle(2);
    rd(4'd1, 32'h0, "R5 once");
    chk(irq, 1'b0, "R10 after clear");
    wr(4'd5, 32'd50);
    wr(4'd6, 32'h0);
    idle(2);
    rd(4'd1, 32'h2, "R5 already past");
    // R8 write-one-to-clear
    wr(4'd1, 32'h0);
    rd(4'd1, 32'h2, "R8 zero write");
    wr(4'd1, 32'h1C);
    rd(4'd1, 32'h2, "R8 other bits");
    wr(4'd1, 32'h2);
    rd(4'd1, 32'h0, "R8 cleared");
    // R6 snapshots, time frozen at 105
    ext_evt = 2'b01;
    idle(4);
    rd(4'd1, 32'h4, "R6 ch0 flag");
    rd(4'd7, 32'd105, "R6 ch0 lo");
    rd(4'd8, 32'h0, "R6 ch0 hi");
    rd(4'd9, 32'h0, "R6 ch1 untouched");
    chk(irq, 1'b0, "R10 snap masked");
    wr(4'd0, 32'h4);
    chk(irq, 1'b1, "R10 snap unmasked");
    ext_evt = 2'b00;
    wr(4'd3, 32'h200);
    wr(4'd4, 32'h3);
    ext_evt = 2'b01;
    idle(4);
    rd(4'd1, 32'h4, "R7 flag still set");
    rd(4'd7, 32'h200, "R7 overwrite lo");
    rd(4'd8, 32'h3, "R7 overwrite hi");
    ext_evt = 2'b10;
    idle(4);
    rd(4'd1, 32'hC, "R6 ch1 flag");
    rd(4'd9, 32'h200, "R6 ch1 lo");
    rd(4'd10, 32'h3, "R6 ch1 hi");
    wr(4'd1, 32'hC);
    idle(5);
    rd(4'd1, 32'h0, "R6 level no effect");
    // R9 pps bit and control readback
    wr(4'd0, 32'h1E);
    rd(4'd0, 32'h1E, "R9 ctrl readback");
    wr(4'd1, 32'h10);
    rd(4'd1, 32'h0, "R9 pps zero");
    chk(irq, 1'b0, "R9 no irq");
    // R11 soft reset clears state, keeps config
    ext_evt = 2'b11;
    ext_evt = 2'b00;
    idle(2);
    ext_evt = 2'b01;
    idle(4);
    chk(irq, 1'b1, "R11 event before reset");
    wr(4'd0, 32'h1F);
    idle(1);
    rd(4'd1, 32'h0, "R11 events cleared");
    rd(4'd7, 32'h0, "R11 snap cleared");
    rd(4'd5, 32'd50, "R11 target kept");
    rd(4'd2, 32'h0, "R11 addend kept");
    wr(4'd3, 32'h7);
    wr(4'd4, 32'h7);
    rd(4'd3, 32'h0, "R11 load ignored");
    chk(irq, 1'b0, "R11 irq");
    wr(4'd0, 32'h0);
    idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule